// File: doc/BRIEF.md
# DRAM Device Cycle Decoder

This block models the control side of a 256K x 8 dynamic RAM as synchronous logic. It runs on a clock much faster than the memory strobes and samples the active-low row strobe, column strobe, write enable and output enable on each edge. From the order of the strobe edges it works out what kind of access the controller is running. It latches the row and column addresses, reads and writes a small behavioural storage array, keeps a 9-bit internal refresh row counter and decides when the data pins are driven.

Each recognised cycle is reported on a 3-bit kind code. Every refresh, whether it uses the internal counter or the latched row, gives a one-clock strobe together with the row being refreshed. Only the low bits of the row and column address the storage array. The array size is set by parameters so that the model stays small. Strobe timing limits are not checked.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, dq_oe is 0, rfsh_stb is 0, cyc_kind is 0 (idle) and the internal refresh counter is 0, so the first counter refresh reports row 0.
- R2: When ras_n falls while cas_n is high, addr is latched as the row. When cas_n later falls with we_n high, addr is latched as the column and the stored byte at that row and column appears on dq_out one clock after the sampled edge. cyc_kind then reads 1 (read).
- R3: If we_n is low when cas_n falls, dq_in is stored at the addressed location and cyc_kind reads 2 (early write). dq_oe stays 0 for the whole cycle, even with oe_n low.
- R4: If we_n falls after cas_n has fallen in a read, dq_out keeps the data that was read and dq_in is stored at the latched location on the we_n falling edge. cyc_kind reads 3 (read-modify-write).
- R5: If cas_n is held low after a read while ras_n rises and then falls again, the cycle is a hidden refresh. cyc_kind reads 6, rfsh_stb pulses with the counter row, and dq_out and dq_oe keep the read data valid throughout.
- R6: dq_oe is 1 only while a read result is valid and both cas_n and oe_n are low. It returns to 0 in the same sample in which either cas_n or oe_n is high.
- R7: While ras_n stays low, each further cas_n falling edge latches a new column in the same row and reads it (fast page mode).
- R8: If cas_n is already low when ras_n falls and no read is being held, the cycle is a CAS-before-RAS refresh. cyc_kind reads 5 and rfsh_stb pulses for one clock with rfsh_row equal to the internal counter. The address pins are ignored.
- R9: The internal refresh counter steps by one after each CAS-before-RAS or hidden refresh and wraps from 511 to 0.
- R10: A cycle in which ras_n falls with cas_n high and rises again with no cas_n fall is a RAS-only refresh. On the ras_n rise, cyc_kind reads 4 and rfsh_stb pulses with rfsh_row equal to the latched row. The internal counter and the stored data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Data from the bus for writes |
| dq_out | output | DATA_W | Read data toward the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| cyc_kind | output | 3 | Last classified cycle: 0 idle, 1 read, 2 early write, 3 read-modify-write, 4 RAS-only, 5 CAS-before-RAS, 6 hidden |
| rfsh_stb | output | 1 | One-clock pulse for each refresh |
| rfsh_row | output | ADDR_W | Row refreshed with rfsh_stb |

## Verification
The bench sets up the edge orderings that separate the cycle kinds. A write enable that is already low at the column edge must be an early write, and one that falls later must be a read-modify-write. A decoder that mixes these up would either drive the bus during a write or store data before the old byte is read out. Hidden refresh is checked with output enable held low, so a design that dropped the held read on the second row-strobe fall would show dq_oe going low. The counter is run through a full 512-refresh lap to catch a missing wrap, and address pins carrying a different value during the counter refresh would show up in rfsh_row. A RAS-only cycle placed between counter refreshes would show a skipped counter value if it stepped the counter.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int MROW_W = 4,
  parameter int MCOL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [2:0]        cyc_kind,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row
);

  localparam int IDX_W = MROW_W + MCOL_W;
  localparam int DEPTH = 1 << IDX_W;

  localparam logic [2:0] K_IDLE = 3'd0;
  localparam logic [2:0] K_READ = 3'd1;
  localparam logic [2:0] K_EWR  = 3'd2;
  localparam logic [2:0] K_RMW  = 3'd3;
  localparam logic [2:0] K_ROR  = 3'd4;
  localparam logic [2:0] K_CBR  = 3'd5;
  localparam logic [2:0] K_HID  = 3'd6;

  logic ras_q, cas_q, we_q;
  logic row_open, had_cas, rd_valid;
  logic [ADDR_W-1:0] row_q, col_q, rfsh_cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire cas_rise = ~cas_q & cas_n;
  wire we_fall  = we_q & ~we_n;

  wire pg_cas   = cas_fall & ~ras_n & row_open;
  wire pg_rd    = pg_cas & we_n;
  wire pg_wr    = pg_cas & ~we_n;
  wire rmw_wr   = we_fall & ~cas_n & ~cas_fall & ~ras_n & row_open & rd_valid;
  wire ctr_ref  = ras_fall & ~cas_n;
  wire hid_ref  = ctr_ref & rd_valid;
  wire ras_only = ras_rise & row_open & ~had_cas;

  wire [IDX_W-1:0] idx_now = {row_q[MROW_W-1:0], addr[MCOL_W-1:0]};
  wire [IDX_W-1:0] idx_rmw = {row_q[MROW_W-1:0], col_q[MCOL_W-1:0]};

  assign dq_oe = rd_valid & ~cas_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (pg_wr)
      mem[idx_now] <= dq_in;
    else if (rmw_wr)
      mem[idx_rmw] <= dq_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      row_open <= 1'b0;
      had_cas  <= 1'b0;
      rd_valid <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      rfsh_cnt <= '0;
      dq_out   <= '0;
      cyc_kind <= K_IDLE;
      rfsh_stb <= 1'b0;
      rfsh_row <= '0;
    end else begin
      ras_q    <= ras_n;
      cas_q    <= cas_n;
      we_q     <= we_n;
      rfsh_stb <= ctr_ref | ras_only;

      if (ras_fall && cas_n) begin
        row_open <= 1'b1;
        had_cas  <= 1'b0;
        row_q    <= addr;
      end else if (ras_rise) begin
        row_open <= 1'b0;
      end

      if (pg_cas) begin
        had_cas <= 1'b1;
        col_q   <= addr;
      end

      if (cas_rise || pg_wr)
        rd_valid <= 1'b0;
      else if (pg_rd)
        rd_valid <= 1'b1;

      if (pg_rd)
        dq_out <= mem[idx_now];

      if (ctr_ref) begin
        rfsh_row <= rfsh_cnt;
        rfsh_cnt <= rfsh_cnt + 1'b1;
        cyc_kind <= hid_ref ? K_HID : K_CBR;
      end else if (ras_only) begin
        rfsh_row <= row_q;
        cyc_kind <= K_ROR;
      end else if (pg_rd) begin
        cyc_kind <= K_READ;
      end else if (pg_wr) begin
        cyc_kind <= K_EWR;
      end else if (rmw_wr) begin
        cyc_kind <= K_RMW;
      end
    end
  end

  p_ewr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_kind == K_EWR |-> !dq_oe);

  p_hid_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && cyc_kind == K_HID) |-> rd_valid);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cas_n && $past(rd_valid && !cas_n)) |-> $stable(dq_out));

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && (cyc_kind == K_CBR || cyc_kind == K_HID))
      |-> rfsh_cnt == ADDR_W'(rfsh_row + 1'b1));

  p_ror_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && cyc_kind == K_ROR) |-> rfsh_cnt == $past(rfsh_cnt));

endmodule

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe;
  logic [2:0] cyc_kind;
  logic rfsh_stb;
  logic [8:0] rfsh_row;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] ref_mem [256];
  int cnt_model = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ix(input int row, input int col);
    return ((row & 15) << 4) | (col & 15);
  endfunction

  task automatic idle();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; tick(); tick();
  endtask

  task automatic open_row(input int row);
    addr = 9'(row); ras_n = 0; tick();
  endtask

  task automatic t_reset();
    chk(dq_oe == 0, "R1 dq_oe", dq_oe, 0);
    chk(rfsh_stb == 0, "R1 rfsh_stb", rfsh_stb, 0);
    chk(cyc_kind == 0, "R1 cyc_kind", cyc_kind, 0);
  endtask

  task automatic t_early_write(input int row, input int col, input int d);
    open_row(row);
    addr = 9'(col); dq_in = 8'(d); we_n = 0; oe_n = 0; cas_n = 0; tick();
    chk(cyc_kind == 2, "R3 kind", cyc_kind, 2);
    chk(dq_oe == 0, "R3 no drive", dq_oe, 0);
    tick();
    chk(dq_oe == 0, "R3 no drive later", dq_oe, 0);
    ref_mem[ix(row, col)] = 8'(d);
    idle();
  endtask

  task automatic t_read(input int row, input int col);
    open_row(row);
    addr = 9'(col); cas_n = 0; tick();
    oe_n = 0; #1;
    chk(cyc_kind == 1, "R2 kind", cyc_kind, 1);
    chk(dq_out == ref_mem[ix(row, col)], "R2 data", dq_out, ref_mem[ix(row, col)]);
    chk(dq_oe == 1, "R6 drive", dq_oe, 1);
    oe_n = 1; #1;
    chk(dq_oe == 0, "R6 oe high", dq_oe, 0);
    idle();
  endtask

  task automatic t_page(input int row);
    open_row(row);
    for (int k = 0; k < 3; k++) begin
      addr = 9'(k * 5 + 1); cas_n = 0; oe_n = 0; tick();
      chk(dq_out == ref_mem[ix(row, k * 5 + 1)], "R7 page data", dq_out, ref_mem[ix(row, k * 5 + 1)]);
      chk(dq_oe == 1, "R7 page drive", dq_oe, 1);
      cas_n = 1; #1;
      chk(dq_oe == 0, "R6 cas high", dq_oe, 0);
      tick();
    end
    idle();
  endtask

  task automatic t_rmw(input int row, input int col, input int d);
    open_row(row);
    addr = 9'(col); cas_n = 0; oe_n = 0; tick();
    chk(dq_out == ref_mem[ix(row, col)], "R4 old data", dq_out, ref_mem[ix(row, col)]);
    oe_n = 1; dq_in = 8'(d); we_n = 0; tick();
    chk(cyc_kind == 3, "R4 kind", cyc_kind, 3);
    chk(dq_out == ref_mem[ix(row, col)], "R4 out held", dq_out, ref_mem[ix(row, col)]);
    ref_mem[ix(row, col)] = 8'(d);
    idle();
    t_read(row, col);
  endtask

  task automatic t_cbr(input int junk);
    cas_n = 0; tick();
    addr = 9'(junk); ras_n = 0; tick();
    chk(cyc_kind == 5, "R8 kind", cyc_kind, 5);
    chk(rfsh_stb == 1, "R8 stb", rfsh_stb, 1);
    chk(rfsh_row == 9'(cnt_model), "R9 counter row", rfsh_row, cnt_model);
    tick();
    chk(rfsh_stb == 0, "R8 stb pulse", rfsh_stb, 0);
    cnt_model = (cnt_model + 1) % 512;
    idle();
  endtask

  task automatic t_hidden(input int row, input int col);
    open_row(row);
    addr = 9'(col); cas_n = 0; oe_n = 0; tick();
    ras_n = 1; tick(); tick();
    chk(dq_oe == 1, "R5 drive gap", dq_oe, 1);
    addr = 9'h1AA; ras_n = 0; tick();
    chk(cyc_kind == 6, "R5 kind", cyc_kind, 6);
    chk(rfsh_stb == 1, "R5 stb", rfsh_stb, 1);
    chk(rfsh_row == 9'(cnt_model), "R5 counter row", rfsh_row, cnt_model);
    chk(dq_out == ref_mem[ix(row, col)], "R5 data held", dq_out, ref_mem[ix(row, col)]);
    chk(dq_oe == 1, "R5 drive", dq_oe, 1);
    cnt_model = (cnt_model + 1) % 512;
    idle();
  endtask

  task automatic t_ras_only(input int row);
    open_row(row); tick(); tick();
    ras_n = 1; tick();
    chk(cyc_kind == 4, "R10 kind", cyc_kind, 4);
    chk(rfsh_stb == 1, "R10 stb", rfsh_stb, 1);
    chk(rfsh_row == 9'(row), "R10 row", rfsh_row, row);
    idle();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    t_reset();
    t_cbr(9'h155);
    t_early_write(3, 2, 8'hA5);
    t_early_write(3, 7, 8'h3C);
    t_early_write(9, 2, 8'h5A);
    t_early_write(3, 1, 8'h11);
    t_early_write(3, 6, 8'h66);
    t_early_write(3, 11, 8'hBB);
    t_read(3, 2);
    t_read(9, 2);
    t_read(3, 7);
    t_page(3);
    t_rmw(9, 2, 8'hC7);
    t_hidden(3, 7);
    t_ras_only(9'h0E9);
    t_cbr(9'h0E9);
    t_read(9, 2);
    t_read(14, 2 + 0 * 0);
    for (int n = 0; n < 512; n++) t_cbr(n ^ 9'h0AB);
    t_cbr(0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);

  initial begin
    tick();
    for (int i = 0; i < 256; i++) uut.mem[i] = 8'(i * 7 + 3);
  end
endmodule